// File: doc/BRIEF.md
# Sequential Multiply, Divide and Sign-Extend Unit

This unit carries out the multiply and divide operations of an accumulator-style integer datapath, together with the two accumulator sign-extension operations. It works on the implicit register pair: a byte operation reads the low half of AX, and a word operation reads AX or the DX:AX pair. It writes its result back into the same pair. The surrounding datapath drives the current AX and DX values and the source operand together with a one-cycle start strobe. It then waits for the done strobe and picks up the new AX, DX, carry and overflow values.

Multiplication uses a shift-add engine that consumes one multiplier bit per cycle, starting from the most significant bit. Division uses a restoring engine that produces one quotient bit per cycle. Signed operations run on magnitudes, and the signs are applied in a final cycle. That cycle also checks whether the quotient fits the destination. When the divisor is zero or the quotient does not fit, the unit raises a divide-error indication and leaves AX and DX as they were. The sign extensions finish in a single cycle.

Top module: `muldiv_unit`

## Requirements
- R1: While rst_ni is low, ax_o, dx_o, cf_o, of_o, div_err_o and done_o are all 0.
- R2: op_i=0 is an unsigned multiply. With wide_i=0 it gives ax_o = ax_i[7:0]*src_i[7:0] and dx_o = dx_i. With wide_i=1 it gives {dx_o,ax_o} = ax_i*src_i.
- R3: After an unsigned multiply, cf_o and of_o are equal. They are 1 exactly when the upper half of the product (ax_o[15:8] for a byte operation, dx_o for a word operation) is nonzero.
- R4: op_i=1 is a signed multiply with the same operand and result placement as R2. The result is sign-filled. cf_o and of_o are 1 exactly when the upper half differs from the sign extension of the lower half.
- R5: op_i=2 is an unsigned divide. A byte divide takes ax_i by src_i[7:0], puts the quotient in ax_o[7:0] and the remainder in ax_o[15:8], and leaves dx_o = dx_i. A word divide takes {dx_i,ax_i} by src_i, puts the quotient in ax_o and the remainder in dx_o.
- R6: op_i=3 is a signed divide with the placement of R5. The dividend is ax_i or {dx_i,ax_i} read as two's complement. The quotient truncates toward zero, and a nonzero remainder has the sign of the dividend.
- R7: A divide with a zero divisor, or with a quotient outside the destination range, raises div_err_o together with done_o and leaves ax_o = ax_i and dx_o = dx_i. The range is 0..255 or 0..65535 when unsigned, and -128..127 or -32768..32767 when signed.
- R8: op_i=4 or 6 is a byte-to-word sign extension: ax_o[15:8] becomes ax_i[7]. op_i=5 or 7 is a word-to-double sign extension: dx_o becomes 16 copies of ax_i[15]. done_o rises in the cycle after start is taken, and cf_o and of_o keep their values.
- R9: For a multiply or divide taken at clock edge k, done_o is high for exactly one cycle, from edge k+W+1, where W is 8 for a byte operation and 16 for a word operation. The results appear at that same edge and hold until the next done.
- R10: A start_i pulse that arrives while a multiply or divide is in progress is ignored. This includes a pulse at the edge where that operation finishes.
- R11: Unsigned and signed divides leave cf_o and of_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin an operation |
| op_i | input | 3 | Operation code, see R2 to R8 |
| wide_i | input | 1 | 0 selects byte width, 1 selects word width |
| ax_i | input | 16 | Current accumulator |
| dx_i | input | 16 | Current extension register |
| src_i | input | 16 | Source operand (the low byte is used for byte operations) |
| ax_o | output | 16 | New accumulator |
| dx_o | output | 16 | New extension register |
| cf_o | output | 1 | Carry flag result |
| of_o | output | 1 | Overflow flag result |
| div_err_o | output | 1 | Divide error, valid with done_o |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
Unsigned multiplies run on small operands and on all-ones operands. The all-ones cases separate an empty upper half from a full one, and so show whether the flags track the high half. Signed multiplies use mixed signs and the most negative value. These cases separate a correct sign-fill from a magnitude-only result, and a true overflow from a merely negative product. Divides cover exact and inexact quotients, each sign combination, quotients of exactly -128 and +128, and a zero divisor. These cases separate truncation toward zero from flooring, and in-range quotients from the divide-error path. Start pulses issued mid-operation and on the finishing edge show whether a busy unit ignores new requests. A start issued in the done cycle shows that an idle unit takes it.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [2:0] {
    OP_MUL      = 3'd0,
    OP_IMUL     = 3'd1,
    OP_DIV      = 3'd2,
    OP_IDIV     = 3'd3,
    OP_SXB      = 3'd4,
    OP_SXW      = 3'd5,
    OP_SXB_ALT  = 3'd6,
    OP_SXW_ALT  = 3'd7
  } muldiv_op_e;
endpackage

// File: rtl/muldiv_mul_core.sv
module muldiv_mul_core #(
  parameter int DW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            step_i,
  input  logic [DW-1:0]   mplier_i,
  input  logic [DW-1:0]   mcand_i,
  output logic [2*DW-1:0] prod_o
);
  logic [2*DW-1:0] acc_q;
  logic [DW-1:0]   mq_q, mc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      mq_q  <= '0;
      mc_q  <= '0;
    end else if (load_i) begin
      acc_q <= '0;
      mq_q  <= mplier_i;
      mc_q  <= mcand_i;
    end else if (step_i) begin
      // msb-first: shift accumulated sum, add multiplicand on a set bit
      acc_q <= {acc_q[2*DW-2:0], 1'b0} + (mq_q[DW-1] ? {{DW{1'b0}}, mc_q} : '0);
      mq_q  <= {mq_q[DW-2:0], 1'b0};
    end
  end

  assign prod_o = acc_q;
endmodule

// File: rtl/muldiv_div_core.sv
module muldiv_div_core #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] dvs_i,
  output logic [DW-1:0] quo_o,
  output logic [DW-1:0] rem_o
);
  logic [DW-1:0] r_q, q_q, d_q;
  logic [DW:0]   trial, diff;
  logic          fits;

  always_comb begin
    trial = {r_q, q_q[DW-1]};
    diff  = trial - {1'b0, d_q};
    fits  = trial >= {1'b0, d_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q <= '0;
      q_q <= '0;
      d_q <= '0;
    end else if (load_i) begin
      r_q <= hi_i;
      q_q <= lo_i;
      d_q <= dvs_i;
    end else if (step_i) begin
      r_q <= fits ? diff[DW-1:0] : trial[DW-1:0];
      q_q <= {q_q[DW-2:0], fits};
    end
  end

  assign quo_o = q_q;
  assign rem_o = r_q;
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic          wide_i,
  input  logic [DW-1:0] ax_i,
  input  logic [DW-1:0] dx_i,
  input  logic [DW-1:0] src_i,
  output logic [DW-1:0] ax_o,
  output logic [DW-1:0] dx_o,
  output logic          cf_o,
  output logic          of_o,
  output logic          div_err_o,
  output logic          done_o
);
  localparam int HW = DW / 2;
  localparam int CW = $clog2(DW + 1);

  logic          busy_q, wide_q, neg_a_q, neg_b_q, err_q;
  logic [CW-1:0] cnt_q, lim_q;
  logic [2:0]    op_q;
  logic [DW-1:0] ax_q, dx_q;

  logic accept, is_ext, is_sgn, is_div, last_it;
  assign accept  = start_i & ~busy_q;
  assign is_ext  = op_i[2];
  assign is_sgn  = op_i[0];
  assign is_div  = op_i[1];
  assign last_it = busy_q & (cnt_q == lim_q);

  // operand preparation: magnitudes and signs
  logic [DW-1:0]   a_val, a_mag, s_val, s_mag, mq_ld, dv_hi, dv_lo;
  logic [2*DW-1:0] dvd_val, dvd_mag;
  logic            a_neg, s_neg, dvd_neg, pre_err;

  always_comb begin
    a_val   = wide_i ? ax_i : {{HW{is_sgn & ax_i[HW-1]}}, ax_i[HW-1:0]};
    a_neg   = is_sgn & a_val[DW-1];
    a_mag   = a_neg ? -a_val : a_val;
    s_val   = wide_i ? src_i : {{HW{is_sgn & src_i[HW-1]}}, src_i[HW-1:0]};
    s_neg   = is_sgn & s_val[DW-1];
    s_mag   = s_neg ? -s_val : s_val;
    mq_ld   = wide_i ? a_mag : {a_mag[HW-1:0], {HW{1'b0}}};
    dvd_val = wide_i ? {dx_i, ax_i} : {{DW{is_sgn & ax_i[DW-1]}}, ax_i};
    dvd_neg = is_sgn & dvd_val[2*DW-1];
    dvd_mag = dvd_neg ? -dvd_val : dvd_val;
    dv_hi   = wide_i ? dvd_mag[2*DW-1:DW] : {{HW{1'b0}}, dvd_mag[DW-1:HW]};
    dv_lo   = wide_i ? dvd_mag[DW-1:0] : {dvd_mag[HW-1:0], {HW{1'b0}}};
    // quotient magnitude >= 2^W, also catches a zero divisor
    pre_err = dv_hi >= s_mag;
  end

  logic core_ld, core_step;
  assign core_ld   = accept & ~is_ext;
  assign core_step = busy_q & ~last_it;

  logic [2*DW-1:0] prod;
  logic [DW-1:0]   quo, rem;

  muldiv_mul_core #(.DW(DW)) u_mul (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (core_ld),
    .step_i  (core_step),
    .mplier_i(mq_ld),
    .mcand_i (s_mag),
    .prod_o  (prod)
  );

  muldiv_div_core #(.DW(DW)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(core_ld),
    .step_i(core_step),
    .hi_i  (dv_hi),
    .lo_i  (dv_lo),
    .dvs_i (s_mag),
    .quo_o (quo),
    .rem_o (rem)
  );

  // final cycle: sign application and range checks
  logic [2*DW-1:0] prod_s;
  logic [DW-1:0]   quo_s, rem_s, q_lim;
  logic            neg_res, mul_ovf, sgn_ovf, fin_err;

  always_comb begin
    neg_res = neg_a_q ^ neg_b_q;
    prod_s  = neg_res ? -prod : prod;
    quo_s   = neg_res ? -quo : quo;
    rem_s   = neg_a_q ? -rem : rem;
    if (op_q[0])
      mul_ovf = wide_q ? (prod_s[2*DW-1:DW] != {DW{prod_s[DW-1]}})
                       : (prod_s[DW-1:HW] != {HW{prod_s[HW-1]}});
    else
      mul_ovf = wide_q ? (|prod_s[2*DW-1:DW]) : (|prod_s[DW-1:HW]);
    q_lim   = wide_q ? (DW'(1) << (DW - 1)) : (DW'(1) << (HW - 1));
    sgn_ovf = op_q[0] & (neg_res ? (quo > q_lim) : (quo >= q_lim));
    fin_err = err_q | sgn_ovf;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      lim_q     <= '0;
      op_q      <= 3'd0;
      wide_q    <= 1'b0;
      ax_q      <= '0;
      dx_q      <= '0;
      neg_a_q   <= 1'b0;
      neg_b_q   <= 1'b0;
      err_q     <= 1'b0;
      ax_o      <= '0;
      dx_o      <= '0;
      cf_o      <= 1'b0;
      of_o      <= 1'b0;
      div_err_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      div_err_o <= 1'b0;
      if (accept) begin
        op_q   <= op_i;
        wide_q <= wide_i;
        ax_q   <= ax_i;
        dx_q   <= dx_i;
        if (is_ext) begin
          done_o <= 1'b1;
          if (op_i[0]) begin
            ax_o <= ax_i;
            dx_o <= {DW{ax_i[DW-1]}};
          end else begin
            ax_o <= {{HW{ax_i[HW-1]}}, ax_i[HW-1:0]};
            dx_o <= dx_i;
          end
        end else begin
          busy_q  <= 1'b1;
          cnt_q   <= '0;
          lim_q   <= wide_i ? CW'(DW) : CW'(HW);
          neg_a_q <= is_div ? dvd_neg : a_neg;
          neg_b_q <= s_neg;
          err_q   <= is_div & pre_err;
        end
      end else if (busy_q) begin
        if (last_it) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
          if (op_q[1]) begin
            div_err_o <= fin_err;
            if (fin_err) begin
              ax_o <= ax_q;
              dx_o <= dx_q;
            end else if (wide_q) begin
              ax_o <= quo_s;
              dx_o <= rem_s;
            end else begin
              ax_o <= {rem_s[HW-1:0], quo_s[HW-1:0]};
              dx_o <= dx_q;
            end
          end else begin
            cf_o <= mul_ovf;
            of_o <= mul_ovf;
            ax_o <= prod_s[DW-1:0];
            dx_o <= wide_q ? prod_s[2*DW-1:DW] : dx_q;
          end
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end
endmodule

module muldiv_unit_chk
  import muldiv_pkg::*;
#(
  parameter int DW = 16
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       busy_i,
  input logic [$clog2(DW+1)-1:0]    cnt_i,
  input logic [$clog2(DW+1)-1:0]    lim_i,
  input logic [2:0]                 op_q_i,
  input logic                       wide_q_i,
  input logic [DW-1:0]              ax_q_i,
  input logic [DW-1:0]              dx_q_i,
  input logic [DW-1:0]              ax_o,
  input logic [DW-1:0]              dx_o,
  input logic                       cf_o,
  input logic                       of_o,
  input logic                       div_err_o,
  input logic                       done_o
);
  localparam int HW = DW / 2;

  p_err_with_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_err_o |-> done_o);

  p_err_keeps_regs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && div_err_o) |-> (ax_o == ax_q_i && dx_o == dx_q_i));

  p_div_flags_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q_i[1] && !op_q_i[2]) |-> ($stable(cf_o) && $stable(of_o)));

  p_ext_flags_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q_i[2]) |-> ($stable(cf_o) && $stable(of_o)));

  p_ext_dword_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q_i[2] && op_q_i[0]) |-> (dx_o == {DW{ax_o[DW-1]}}));

  p_mul_flags_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q_i == OP_MUL && !wide_q_i) |-> (cf_o == (ax_o[DW-1:HW] != '0) && of_o == cf_o));

  p_busy_ignores_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(op_q_i) && $stable(ax_q_i) && $stable(dx_q_i)));

  p_count_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (cnt_i <= lim_i));

  p_finish_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && cnt_i == lim_i) |=> (done_o && !busy_i));

  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_i);
endmodule

bind muldiv_unit muldiv_unit_chk #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_i   (busy_q),
  .cnt_i    (cnt_q),
  .lim_i    (lim_q),
  .op_q_i   (op_q),
  .wide_q_i (wide_q),
  .ax_q_i   (ax_q),
  .dx_q_i   (dx_q),
  .ax_o     (ax_o),
  .dx_o     (dx_o),
  .cf_o     (cf_o),
  .of_o     (of_o),
  .div_err_o(div_err_o),
  .done_o   (done_o)
);

// File: tb/muldiv_unit_test.sv
`timescale 1ns/1ps
module muldiv_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        wide = 1'b0;
  logic [15:0] ax = '0, dx = '0, src = '0;
  logic [15:0] ax_o, dx_o;
  logic        cf_o, of_o, err_o, done_o;

  always #2 clk = ~clk;

  muldiv_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .wide_i(wide),
    .ax_i(ax), .dx_i(dx), .src_i(src),
    .ax_o(ax_o), .dx_o(dx_o), .cf_o(cf_o), .of_o(of_o),
    .div_err_o(err_o), .done_o(done_o)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // reference model state
  int          m_cnt = 0;
  logic [15:0] e_ax = '0, e_dx = '0;
  logic        e_cf = 0, e_of = 0, e_err = 0, e_done = 0;
  string       e_tag = "R1";
  logic [15:0] p_ax, p_dx;
  logic        p_cf, p_of, p_err;
  string       p_tag;

  task automatic calc(input logic [2:0] o, input logic wd,
                      input logic [15:0] a, input logic [15:0] d, input logic [15:0] s);
    longint x, y, q, r, p;
    p_ax = a; p_dx = d; p_cf = e_cf; p_of = e_of; p_err = 0; p_tag = "R8";
    case (o)
      3'd0: begin
        p_tag = "R2 R3";
        if (wd) begin
          p = longint'(a) * longint'(s);
          p_ax = p[15:0]; p_dx = p[31:16]; p_cf = (p[31:16] != 0);
        end else begin
          p = longint'(a[7:0]) * longint'(s[7:0]);
          p_ax = p[15:0]; p_cf = (p[15:8] != 0);
        end
        p_of = p_cf;
      end
      3'd1: begin
        p_tag = "R4";
        x = wd ? longint'($signed(a)) : longint'($signed(a[7:0]));
        y = wd ? longint'($signed(s)) : longint'($signed(s[7:0]));
        p = x * y;
        p_ax = p[15:0];
        if (wd) p_dx = p[31:16];
        p_cf = wd ? (p > 32767 || p < -32768) : (p > 127 || p < -128);
        p_of = p_cf;
      end
      3'd2: begin
        p_tag = "R5 R11";
        x = wd ? longint'({d, a}) : longint'(a);
        y = wd ? longint'(s) : longint'(s[7:0]);
        if (y == 0 || (x / y) > (wd ? 65535 : 255)) begin
          p_err = 1; p_tag = "R7";
        end else begin
          q = x / y; r = x % y;
          if (wd) begin p_ax = q[15:0]; p_dx = r[15:0]; end
          else p_ax = {r[7:0], q[7:0]};
        end
      end
      3'd3: begin
        p_tag = "R6 R11";
        x = wd ? longint'($signed({d, a})) : longint'($signed(a));
        y = wd ? longint'($signed(s)) : longint'($signed(s[7:0]));
        if (y == 0) begin
          p_err = 1; p_tag = "R7";
        end else begin
          q = x / y; r = x % y;
          if (wd ? (q > 32767 || q < -32768) : (q > 127 || q < -128)) begin
            p_err = 1; p_tag = "R7";
          end else if (wd) begin
            p_ax = q[15:0]; p_dx = r[15:0];
          end else p_ax = {r[7:0], q[7:0]};
        end
      end
      3'd4, 3'd6: p_ax = {{8{a[7]}}, a[7:0]};
      default:    p_dx = {16{a[15]}};
    endcase
  endtask

  task automatic apply_pending();
    e_ax = p_ax; e_dx = p_dx; e_cf = p_cf; e_of = p_of;
    e_err = p_err; e_done = 1; e_tag = p_tag;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; e_ax = '0; e_dx = '0; e_cf = 0; e_of = 0; e_err = 0; e_done = 0;
    end else begin
      bit idle;
      e_done = 0; e_err = 0;
      idle = (m_cnt == 0);
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) apply_pending();
      end
      // R10: start only taken when idle
      if (idle && start) begin
        calc(op, wide, ax, dx, src);
        if (op[2]) apply_pending();     // R8: one-cycle extension
        else m_cnt = wide ? 17 : 9;     // R9: W+1 cycles
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (!finished) begin
      if (!rst_n) begin
        total++;
        if (ax_o !== 0 || dx_o !== 0 || cf_o !== 0 || of_o !== 0 || err_o !== 0 || done_o !== 0) begin
          bad++;
          $display("FAIL R1 reset: ax=%h dx=%h cf=%b of=%b err=%b done=%b expected all zero",
                   ax_o, dx_o, cf_o, of_o, err_o, done_o);
        end
      end else begin
        total++;
        if (done_o !== e_done || ax_o !== e_ax || dx_o !== e_dx || cf_o !== e_cf ||
            of_o !== e_of || err_o !== e_err) begin
          bad++;
          $display("FAIL %s: ax=%h dx=%h cf=%b of=%b err=%b done=%b expected ax=%h dx=%h cf=%b of=%b err=%b done=%b",
                   e_done ? e_tag : "R9", ax_o, dx_o, cf_o, of_o, err_o, done_o,
                   e_ax, e_dx, e_cf, e_of, e_err, e_done);
        end
      end
    end
  end

  task automatic drive(input logic [2:0] o, input logic wd,
                       input logic [15:0] a, input logic [15:0] d, input logic [15:0] s);
    op = o; wide = wd; ax = a; dx = d; src = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_op(input logic [2:0] o, input logic wd,
                        input logic [15:0] a, input logic [15:0] d, input logic [15:0] s);
    @(negedge clk);
    drive(o, wd, a, d, s);
    while (m_cnt != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 unsigned multiply
    run_op(3'd0, 0, 16'h5512, 16'hBEEF, 16'h0034);
    run_op(3'd0, 0, 16'h00FF, 16'h1111, 16'h00FF);
    run_op(3'd0, 1, 16'h1234, 16'h0000, 16'h0100);
    run_op(3'd0, 1, 16'hFFFF, 16'h0000, 16'hFFFF);
    run_op(3'd0, 1, 16'h00FF, 16'h7777, 16'h0101);
    // R4 signed multiply
    run_op(3'd1, 0, 16'h00FE, 16'h2222, 16'h0005);
    run_op(3'd1, 0, 16'h0080, 16'h2222, 16'h0080);
    run_op(3'd1, 0, 16'h0080, 16'h2222, 16'h0001);
    run_op(3'd1, 1, 16'h8000, 16'h0000, 16'hFFFF);
    run_op(3'd1, 1, 16'hFF9C, 16'h0000, 16'h0064);
    // R5 unsigned divide
    run_op(3'd2, 0, 16'd1000, 16'h3333, 16'h0007);
    run_op(3'd2, 1, 16'h0000, 16'h0001, 16'h0003);
    run_op(3'd2, 0, 16'h00FF, 16'h0000, 16'h0001);
    // R6 signed divide, sign combinations and range edges
    run_op(3'd3, 0, 16'hFFF9, 16'h4444, 16'h0002);
    run_op(3'd3, 0, 16'h0007, 16'h4444, 16'h00FE);
    run_op(3'd3, 0, 16'hFFF9, 16'h4444, 16'h00FE);
    run_op(3'd3, 0, 16'hFF00, 16'h4444, 16'h0002);
    run_op(3'd3, 1, 16'h7960, 16'hFFFE, 16'h0007);
    // R7 divide errors
    run_op(3'd2, 0, 16'h1234, 16'h5555, 16'h0000);
    run_op(3'd2, 0, 16'h1000, 16'h5555, 16'h0010);
    run_op(3'd2, 1, 16'h0000, 16'h0005, 16'h0005);
    run_op(3'd3, 0, 16'h0100, 16'h6666, 16'h0002);
    run_op(3'd3, 0, 16'h8000, 16'h6666, 16'h00FF);
    run_op(3'd3, 1, 16'h0000, 16'h8000, 16'hFFFF);
    // R8 sign extensions
    run_op(3'd4, 0, 16'h1280, 16'h7777, 16'h0000);
    run_op(3'd6, 0, 16'hAB7F, 16'h7777, 16'h0000);
    run_op(3'd5, 0, 16'h8000, 16'h0000, 16'h0000);
    run_op(3'd7, 0, 16'h1234, 16'hFFFF, 16'h0000);

    // R10 start while busy: mid-run and on the finishing edge
    @(negedge clk);
    drive(3'd0, 0, 16'h0003, 16'h0000, 16'h0005);
    repeat (2) @(negedge clk);
    drive(3'd2, 0, 16'h0009, 16'h0000, 16'h0000);
    while (m_cnt != 1) @(negedge clk);
    drive(3'd4, 0, 16'h0080, 16'h0000, 16'h0000);
    repeat (3) @(negedge clk);
    total++;
    if (ax_o !== 16'h000F || done_o !== 1'b0) begin
      bad++;
      $display("FAIL R10: ax=%h done=%b expected ax=000f done=0", ax_o, done_o);
    end

    // R9 back-to-back: new start in the done cycle is taken
    @(negedge clk);
    drive(3'd1, 0, 16'h0007, 16'h0000, 16'h00FD);
    while (m_cnt != 0) @(negedge clk);
    drive(3'd5, 0, 16'hF000, 16'h0000, 16'h0000);
    repeat (3) @(negedge clk);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R9 watchdog: run did not complete, expected completion within 20000 cycles");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule